// File: doc/BRIEF.md
# Dithered Quadrature NCO

This block is a numerically controlled oscillator that delivers one cosine sample and one sine sample on every clock. Together they form a quadrature local oscillator running at the full sample rate. A 32-bit tuning word sets the phase increment. Each clock, the increment is added to a 32-bit phase register. The twelve most significant bits of the phase select an amplitude from a quarter-wave sine table, and the table is folded to cover all four quadrants. The cosine is read from the same table at a phase a quarter turn ahead.

Cutting the phase down to twelve bits produces periodic errors, and these appear as spurious tones. An optional pseudo-random dither, taken from a maximal-length shift register, can be added to the low phase bits before the cut. This spreads the error energy into a noise-like floor. The downstream mixer uses the outputs whenever the valid flag is high.

Top module: `nco_quad`

## Requirements
- R1: On every clock edge without reset, the phase register advances by the active tuning word, modulo 2^32.
- R2: When ftw_load is high at a clock edge, ftw_in is captured at that edge and is used as the increment from the following edge onward. Loading a word never clears the accumulated phase.
- R3: A clock edge with rst high clears the phase, the active tuning word and the outputs. While rst is held, cos_out, sin_out and out_valid read 0.
- R4: An output pair appears three clock edges after the phase value it is derived from. After reset is released, out_valid first rises after the third edge.
- R5: At phase zero with dither off, cos_out is 32767 and sin_out is 0.
- R6: Let n be bits [31:20] of the dithered phase. Then sin_out equals round(32767*sin(2*pi*n/4096)) within 1 LSB, and cos_out equals the same formula at index (n+1024) mod 4096. All four quadrants come from one 1024-entry quarter table through mirroring and negation.
- R7: With dither_en low, n equals bits [31:20] of the phase register exactly.
- R8: With dither_en high, a 16-bit value from a maximal-length shift register (taps at bits 15, 13, 12 and 10, non-zero seed) is added to the low 16 phase bits before the cut. The index is then n or n+1, and the register never reaches zero.
- R9: Outputs stay within plus or minus 32767 and never take the value -32768.
- R10: Once out_valid is high, it stays high every clock until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw_in | input | 32 | Tuning word to be loaded |
| ftw_load | input | 1 | Captures ftw_in at this edge |
| dither_en | input | 1 | Adds pseudo-random phase dither when high |
| cos_out | output | 16 | Signed cosine sample |
| sin_out | output | 16 | Signed sine sample |
| out_valid | output | 1 | Output pair is valid |

## Verification
The assertions assume that reset is asserted at the first clock edge, so the shift register starts from its seed and the valid pipeline starts empty. They also assume that the tuning inputs are stable at each rising edge. The bench drives every input on the falling edge and holds reset for several cycles at start and again in the middle of the run, so both assumptions hold. The quadrature magnitude assertion depends on the cosine and sine sharing one dithered phase index. That holds for any tuning word, so the stimulus covers quadrant-sized steps, negative steps and small fractional steps with dither both on and off.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int PHASE_W   = 32;
    localparam int IDX_W     = 12;
    localparam int AMP_W     = 16;
    localparam int LFSR_W    = 16;
    localparam int DITH_W    = 16;
    localparam int QTR_W     = IDX_W - 2;
    localparam int FULL      = (1 << (AMP_W - 1)) - 1;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    // folded read request for one quadrature channel
    typedef struct packed {
        logic [QTR_W-1:0] ridx;
        logic             neg;
        logic             peak;
    } fold_t;

    // sign information carried alongside the table read
    typedef struct packed {
        logic neg;
        logic peak;
    } side_t;

    function automatic fold_t fold_addr(input logic [IDX_W-1:0] a);
        fold_t f;
        logic [QTR_W-1:0] k;
        k      = a[QTR_W-1:0];
        f.neg  = a[IDX_W-1];
        f.ridx = a[QTR_W] ? (QTR_W'(0) - k) : k;
        f.peak = a[QTR_W] && (k == '0);
        return f;
    endfunction
endpackage

// File: rtl/nco_phase_gen.sv
module nco_phase_gen
    import nco_pkg::*;
#(
    parameter int PW = PHASE_W,
    parameter int IW = IDX_W,
    parameter int LW = LFSR_W,
    parameter int DW = DITH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] ftw_in,
    input  logic          ftw_load,
    input  logic          dither_en,
    output logic [IW-1:0] sin_idx,
    output logic [IW-1:0] cos_idx
);
    localparam int SHIFT = PW - IW;
    localparam logic [IW-1:0] QUARTER = IW'(1) << (IW - 2);

    logic [PW-1:0] ftw_q;
    logic [PW-1:0] acc_q;
    logic [LW-1:0] lfsr_q;
    logic [PW-1:0] dith;

    always_ff @(posedge clk) begin
        if (rst) begin
            ftw_q  <= '0;
            acc_q  <= '0;
            lfsr_q <= LFSR_SEED;
        end else begin
            acc_q  <= acc_q + ftw_q;
            lfsr_q <= {lfsr_q[LW-2:0], ^(lfsr_q & LFSR_TAPS)};
            if (ftw_load) ftw_q <= ftw_in;
        end
    end

    always_comb begin
        dith    = dither_en ? PW'(lfsr_q[DW-1:0]) : '0;
        sin_idx = IW'((acc_q + dith) >> SHIFT);
        cos_idx = sin_idx + QUARTER;
    end

    // R8: the dither source never locks up in the all-zero state
    a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);
endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom
    import nco_pkg::*;
#(
    parameter int QW = QTR_W,
    parameter int AW = AMP_W
) (
    input  logic          clk,
    input  logic [QW-1:0] addr_a,
    input  logic [QW-1:0] addr_b,
    output logic [AW-2:0] q_a,
    output logic [AW-2:0] q_b
);
    localparam int  N     = 1 << QW;
    localparam real STEP  = 3.14159265358979 / (2.0 * N);
    localparam real SCALE = real'((1 << (AW - 1)) - 1);

    logic [AW-2:0] tbl [N];

    for (genvar i = 0; i < N; i++) begin : g_tbl
        localparam int V = int'(SCALE * $sin(STEP * i));
        assign tbl[i] = (AW-1)'(V);
    end

    always_ff @(posedge clk) begin
        q_a <= tbl[addr_a];
        q_b <= tbl[addr_b];
    end
endmodule

// File: rtl/nco_quad.sv
module nco_quad
    import nco_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [31:0]             ftw_in,
    input  logic                    ftw_load,
    input  logic                    dither_en,
    output logic signed [15:0]      cos_out,
    output logic signed [15:0]      sin_out,
    output logic                    out_valid
);
    localparam int LAT = 3;

    logic [IDX_W-1:0] sin_idx, cos_idx;
    fold_t            s1_sin, s1_cos;
    side_t            s2_sin, s2_cos;
    logic [AMP_W-2:0] rom_sin, rom_cos;
    logic [LAT-1:0]   vld;

    nco_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .ftw_in   (ftw_in),
        .ftw_load (ftw_load),
        .dither_en(dither_en),
        .sin_idx  (sin_idx),
        .cos_idx  (cos_idx)
    );

    // stage 1: quadrant fold
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_sin <= '0;
            s1_cos <= '0;
        end else begin
            s1_sin <= fold_addr(sin_idx);
            s1_cos <= fold_addr(cos_idx);
        end
    end

    // stage 2: shared quarter table, two read ports
    nco_quarter_rom u_rom (
        .clk   (clk),
        .addr_a(s1_sin.ridx),
        .addr_b(s1_cos.ridx),
        .q_a   (rom_sin),
        .q_b   (rom_cos)
    );

    always_ff @(posedge clk) begin
        s2_sin <= '{neg: s1_sin.neg, peak: s1_sin.peak};
        s2_cos <= '{neg: s1_cos.neg, peak: s1_cos.peak};
    end

    function automatic logic signed [AMP_W-1:0] unfold(input side_t s,
                                                        input logic [AMP_W-2:0] m);
        logic signed [AMP_W-1:0] v;
        v = s.peak ? AMP_W'(FULL) : $signed({1'b0, m});
        return s.neg ? -v : v;
    endfunction

    // stage 3: sign restore
    always_ff @(posedge clk) begin
        if (rst) begin
            cos_out <= '0;
            sin_out <= '0;
            vld     <= '0;
        end else begin
            cos_out <= unfold(s2_cos, rom_cos);
            sin_out <= unfold(s2_sin, rom_sin);
            vld     <= {vld[LAT-2:0], 1'b1};
        end
    end

    assign out_valid = vld[LAT-1];

    longint pwr;
    always_comb pwr = longint'(cos_out) * longint'(cos_out)
                    + longint'(sin_out) * longint'(sin_out);

    localparam longint FS2 = longint'(FULL) * longint'(FULL);
    localparam longint TOL = 4 * longint'(FULL);

    // R6: cosine and sine come from one phase, so they lie on the circle
    a_r6_quad_magnitude: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pwr >= FS2 - TOL) && (pwr <= FS2 + TOL));
    // R9: symmetric output range
    a_r9_no_min_code: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cos_out != -16'sd32768) && (sin_out != -16'sd32768));
    // R5: a zero sine means the cosine sits at a full-scale peak
    a_r5_peak_at_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sin_out == 0) |-> (cos_out == FULL || cos_out == -FULL));
    // R10: valid never drops outside reset
    a_r10_valid_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);
endmodule

// File: tb/nco_quad_bench.sv
module nco_quad_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] ftw_in = '0;
    logic ftw_load = 1'b0;
    logic dither_en = 1'b0;
    logic signed [15:0] cos_out, sin_out;
    logic out_valid;

    always #4 clk = ~clk;

    nco_quad u_nco_quad (
        .clk(clk), .rst(rst), .ftw_in(ftw_in), .ftw_load(ftw_load),
        .dither_en(dither_en), .cos_out(cos_out), .sin_out(sin_out),
        .out_valid(out_valid)
    );

    int n_cmp = 0, n_bad = 0, up_hits = 0, valid_drops = 0;
    bit prev_v = 1'b0;
    bit done = 1'b0;

    typedef struct { int idx; bit dith; } exp_t;
    exp_t sb[$];
    logic [31:0] m_acc = '0, m_ftw = '0;

    function automatic int amp(int idx);
        return int'(32767.0 * $sin(2.0 * 3.14159265358979 * idx / 4096.0));
    endfunction

    function automatic bit near(int a, int e);
        return (a - e <= 1) && (e - a <= 1);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // driver-side model: pushes the expected index for each sampled phase
    always @(posedge clk) begin
        if (rst) begin
            m_acc = '0;
            m_ftw = '0;
            sb.delete();
        end else begin
            sb.push_back('{int'(m_acc[31:20]), dither_en});
            m_acc = m_acc + m_ftw;     // R1
            if (ftw_load) m_ftw = ftw_in;  // R2: used from the next edge
        end
    end

    // monitor: pops and compares each valid output pair
    always @(negedge clk) begin
        if (rst) prev_v = 1'b0;
        else begin
            if (prev_v && !out_valid) valid_drops++;
            prev_v = out_valid;
        end
        if (out_valid && !rst) begin
            if (sb.size() == 0) check(1'b0, "R4 no expected item", 1, 0);
            else begin
                exp_t e;
                int es, ec, n2;
                bit ok;
                e  = sb.pop_front();
                es = amp(e.idx);
                ec = amp((e.idx + 1024) % 4096);
                ok = near(sin_out, es) && near(cos_out, ec);
                if (!ok && e.dith) begin
                    n2 = (e.idx + 1) % 4096;
                    ok = near(sin_out, amp(n2)) && near(cos_out, amp((n2 + 1024) % 4096));
                    if (ok) up_hits++;
                end
                ok = ok && (sin_out != -32768) && (cos_out != -32768); // R9
                check(ok, e.dith ? "R1 R2 R6 R8 R9 sin" : "R1 R2 R6 R7 R9 sin",
                      int'(sin_out), es);
            end
        end
    end

    task automatic load(logic [31:0] w, bit d, int cycles);
        @(negedge clk);
        ftw_in = w; ftw_load = 1'b1; dither_en = d;
        @(negedge clk);
        ftw_load = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R3: reset state
        check(out_valid == 1'b0, "R3 valid in reset", int'(out_valid), 0);
        check(cos_out == 0 && sin_out == 0, "R3 outputs in reset", int'(cos_out), 0);
        rst = 1'b0;
        // R4: three-edge latency
        @(negedge clk);
        check(out_valid == 1'b0, "R4 valid after edge 1", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R4 valid after edge 2", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R4 valid after edge 3", int'(out_valid), 1);
        // R5: phase zero
        check(cos_out == 32767, "R5 cos at zero", int'(cos_out), 32767);
        check(sin_out == 0, "R5 sin at zero", int'(sin_out), 0);

        load(32'h0070_3039, 1'b0, 500);   // fractional step, dither off (R7)
        load(32'h4000_0000, 1'b0, 100);   // exact quadrant steps (R6)
        load(32'hFFF0_0000, 1'b0, 300);   // negative step, wraps (R1)
        up_hits = 0;
        load(32'h0001_1111, 1'b1, 3000);  // dither on (R8)
        check(up_hits > 0, "R8 dither reaches next index", up_hits, 1);
        load(32'h0003_3333, 1'b0, 500);   // dither off again (R7)

        // R3: reset mid-run clears phase and word
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && cos_out == 0 && sin_out == 0,
              "R3 mid-run reset", int'(out_valid), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(cos_out == 32767 && sin_out == 0, "R5 zero after reset", int'(cos_out), 32767);
        load(32'h1234_5678, 1'b1, 400);
        check(valid_drops == 0, "R10 valid continuity", valid_drops, 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule